// File: doc/BRIEF.md
# Bus Traffic Event Counter Unit

This block watches one bus port and keeps running statistics on it. A free-running cycle counter measures elapsed time. Four event counters each count a chosen kind of data beat: read beats, write beats, or both together. The beats arrive from the port as single-cycle strobes. Software builds a utilisation figure from two values it reads: the chosen event count and the cycle count.

Software reaches the block through a simple 32-bit register port. A write is a one-cycle strobe with an address and data. A read is combinational from the address. One control write can zero the counters and start them at once. Clearing the master enable freezes every counter, so the values can then be read as one consistent snapshot. Enable bits are changed one at a time through two registers: one that sets bits and one that clears them. Event counter 3 is 40 bits wide, so it is read as an 8-bit high word and a 32-bit low word.

Top module: `busmon_counters`

## Requirements
- R1: After reset, the master enable is 0, every counter is 0, every enable bit is 0 and every type select is 0.
- R2: Writing to the enable-set register (byte address 0x04) sets only those enable bits written as 1. Bits 3:0 belong to event counters 0 to 3 and bit 31 belongs to the cycle counter. Reading either 0x04 or 0x08 returns that bitmap.
- R3: Writing to the enable-clear register (byte address 0x08) clears only those enable bits written as 1. It uses the same bit layout as R2.
- R4: The control register is at 0x00. Bit 0 is the master enable, and it reads back as written. Bit 1 zeroes the event counters and bit 2 zeroes the cycle counter. Both reset bits act only for the cycle of the write and always read back as 0. A write of 0x7 zeroes all counters and starts counting.
- R5: Event counter i adds one on each clock edge where three things are all true: the master enable is 1, enable bit i is 1, and a selected strobe is high. The type select for counter i sits at 0x10+4*i, in bits 1:0. Bit 0 selects read beats and bit 1 selects write beats; when both bits are 1 the two strobes are OR-ed. Counters 0 to 2 read at 0x20, 0x24 and 0x28.
- R6: The cycle counter (0x0C) adds one on every clock edge where the master enable and enable bit 31 are both 1.
- R7: While the master enable is 0, no counter changes. Counting resumes once the enable is written back to 1.
- R8: A reset bit wins over an increment in the same cycle. Bit 1 zeroes only the event counters, and bit 2 zeroes only the cycle counter.
- R9: Event counter 3 is 40 bits wide. Bits 39:32 read at 0x2C, with bits 31:8 of that word reading 0. Bits 31:0 read at 0x30.
- R10: Writes to the counter addresses and to unmapped addresses change nothing. Unmapped addresses read 0.
- R11: A change to the master enable or to an enable bit takes effect from the next clock edge. An event in the same cycle as the enabling write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| beat_rd | input | 1 | Read data beat strobe |
| beat_wr | input | 1 | Write data beat strobe |

## Verification
Two functions can fall in the same cycle: a control write carrying a reset bit, and a beat strobe or cycle tick that would otherwise add one. The bench drives reset writes (event-only, cycle-only and both) with both strobes held high and all enables on. The reference model applies the reset after the increment, and it is compared with the register read on every clock. A second overlap is an enable-set write coinciding with a beat. The model counts that beat only from the next edge.

// File: rtl/busmon_counters.sv
module busmon_counters #(
  parameter int ADDR_W = 8,
  parameter int EVT_W  = 32,
  parameter int WIDE_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              beat_rd,
  input  logic              beat_wr
);
  localparam int NCNT = 4;
  localparam int HI_W = WIDE_W - 32;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_CYC  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(8'h30);

  function automatic logic [ADDR_W-1:0] sel_addr(input int k);
    return ADDR_W'(16 + 4 * k);
  endfunction
  function automatic logic [ADDR_W-1:0] cnt_addr(input int k);
    return ADDR_W'(32 + 4 * k);
  endfunction

  logic              run_q;
  logic [NCNT-1:0]   en_q;
  logic              cyc_en_q;
  logic [1:0]        sel_q [NCNT];
  logic [31:0]       cyc_q;
  logic [WIDE_W-1:0] cnt_view [NCNT];

  wire wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  wire wr_set  = bus_wr && (bus_addr == A_SET);
  wire wr_clr  = bus_wr && (bus_addr == A_CLR);
  wire evt_clr = wr_ctrl && bus_wdata[1];
  wire cyc_clr = wr_ctrl && bus_wdata[2];
  wire unused_wdata = ^bus_wdata[30:4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q    <= 1'b0;
      en_q     <= '0;
      cyc_en_q <= 1'b0;
    end else begin
      if (wr_ctrl) run_q <= bus_wdata[0];
      if (wr_set) begin
        en_q     <= en_q | bus_wdata[NCNT-1:0];
        cyc_en_q <= cyc_en_q | bus_wdata[31];
      end else if (wr_clr) begin
        en_q     <= en_q & ~bus_wdata[NCNT-1:0];
        cyc_en_q <= cyc_en_q & ~bus_wdata[31];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 cyc_q <= '0;
    else if (cyc_clr)           cyc_q <= '0;
    else if (run_q && cyc_en_q) cyc_q <= cyc_q + 1'b1;

  for (genvar i = 0; i < NCNT; i++) begin : g_evt
    localparam int W = (i == NCNT - 1) ? WIDE_W : EVT_W;
    logic [W-1:0] c_q;
    logic         hit;
    assign hit = (sel_q[i][0] & beat_rd) | (sel_q[i][1] & beat_wr);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     sel_q[i] <= 2'b00;
      else if (bus_wr && bus_addr == sel_addr(i)) sel_q[i] <= bus_wdata[1:0];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                          c_q <= '0;
      else if (evt_clr)                    c_q <= '0;
      else if (run_q && en_q[i] && hit)    c_q <= c_q + 1'b1;

    assign cnt_view[i] = WIDE_W'(c_q);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata[0] = run_q;
    if (bus_addr == A_SET || bus_addr == A_CLR) begin
      bus_rdata[NCNT-1:0] = en_q;
      bus_rdata[31]       = cyc_en_q;
    end
    if (bus_addr == A_CYC) bus_rdata = cyc_q;
    for (int k = 0; k < NCNT; k++)
      if (bus_addr == sel_addr(k)) bus_rdata[1:0] = sel_q[k];
    for (int k = 0; k < NCNT - 1; k++)
      if (bus_addr == cnt_addr(k)) bus_rdata = cnt_view[k][31:0];
    if (bus_addr == A_HI) bus_rdata[HI_W-1:0] = cnt_view[NCNT-1][WIDE_W-1:32];
    if (bus_addr == A_LO) bus_rdata = cnt_view[NCNT-1][31:0];
  end

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_q & $past(bus_wdata[NCNT-1:0])) == $past(bus_wdata[NCNT-1:0])));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_q & $past(bus_wdata[NCNT-1:0])) == '0));

  // R7
  freeze_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cyc_clr) |=> $stable(cyc_q));

  // R7
  freeze_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !evt_clr) |=> $stable(cnt_view[NCNT-1]));

  // R8
  evt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clr |=> (cnt_view[0] == '0 && cnt_view[NCNT-1] == '0));

  // R8
  cyc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !cyc_clr && run_q && !cyc_en_q) |=> $stable(cyc_q));

  // R9
  hi_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_HI) |-> (bus_rdata[31:HI_W] == '0));

  // R4
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[31:1] == '0));
endmodule

// File: tb/busmon_counters_test.sv
`timescale 1ns/1ps
module busmon_counters_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        beat_rd = 1'b0;
  logic        beat_wr = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  busmon_counters uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .beat_rd(beat_rd), .beat_wr(beat_wr));

  bit              m_run;
  bit [3:0]        m_en;
  bit              m_cen;
  bit [1:0]        m_sel [4];
  longint unsigned m_cnt [4];
  longint unsigned m_cyc;
  logic [15:0]     lfsr = 16'hACE1;

  function automatic longint unsigned mask_of(int i);
    return (i == 3) ? 64'hFF_FFFF_FFFF : 64'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h00: return {31'b0, m_run};
      8'h04, 8'h08: return {m_cen, 27'b0, m_en};
      8'h0C: return m_cyc[31:0];
      8'h10: return {30'b0, m_sel[0]};
      8'h14: return {30'b0, m_sel[1]};
      8'h18: return {30'b0, m_sel[2]};
      8'h1C: return {30'b0, m_sel[3]};
      8'h20: return m_cnt[0][31:0];
      8'h24: return m_cnt[1][31:0];
      8'h28: return m_cnt[2][31:0];
      8'h2C: return {24'b0, m_cnt[3][39:32]};
      8'h30: return m_cnt[3][31:0];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_update(bit w, logic [7:0] a, logic [31:0] d, bit er, bit ew);
    bit [3:0] inc;
    bit cinc;
    for (int i = 0; i < 4; i++)
      inc[i] = m_run && m_en[i] && ((m_sel[i][0] && er) || (m_sel[i][1] && ew));
    cinc = m_run && m_cen;
    for (int i = 0; i < 4; i++) m_cnt[i] = (m_cnt[i] + inc[i]) & mask_of(i);
    m_cyc = (m_cyc + cinc) & 64'hFFFF_FFFF;
    if (w) begin
      if (a == 8'h00) begin
        m_run = d[0];
        if (d[1]) for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        if (d[2]) m_cyc = 0;
      end else if (a == 8'h04) begin
        m_en = m_en | d[3:0]; m_cen = m_cen | d[31];
      end else if (a == 8'h08) begin
        m_en = m_en & ~d[3:0]; m_cen = m_cen & ~d[31];
      end else if (a >= 8'h10 && a <= 8'h1C && a[1:0] == 2'b00) begin
        m_sel[(a - 8'h10) >> 2] = d[1:0];
      end
    end
  endtask

  task automatic step(bit w, logic [7:0] a, logic [31:0] d, bit er, bit ew, string tag);
    logic [31:0] exp;
    bus_wr = w; bus_addr = a; bus_wdata = d; beat_rd = er; beat_wr = ew;
    #1;
    exp = model_read(a);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
    @(posedge clk);
    model_update(w, a, d, er, ew);
    @(negedge clk);
  endtask

  task automatic rd(logic [7:0] a, string tag);
    step(1'b0, a, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    step(1'b1, a, d, 1'b0, 1'b0, tag);
  endtask

  task automatic burst(int n, string tag);
    logic [7:0] addrs [8] = '{8'h0C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h04, 8'h00};
    for (int k = 0; k < n; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1'b0, addrs[k % 8], 32'h0, lfsr[0], lfsr[3], tag);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_run = 0; m_en = 0; m_cen = 0; m_cyc = 0;
    for (int i = 0; i < 4; i++) begin m_sel[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state across the whole map
    for (int a = 0; a <= 8'h34; a += 4) rd(8'(a), "R1");

    // R2 set register, partial then full
    wr(8'h04, 32'h0000_0005, "R2");
    rd(8'h04, "R2"); rd(8'h08, "R2");
    wr(8'h04, 32'h8000_000A, "R2");
    rd(8'h08, "R2");

    // R5 type selects
    wr(8'h10, 32'h1, "R5"); wr(8'h14, 32'h2, "R5");
    wr(8'h18, 32'h3, "R5"); wr(8'h1C, 32'hFFFF_FFFF, "R5");
    for (int i = 0; i < 4; i++) rd(8'(8'h10 + 4 * i), "R5");

    // R4 start with zeroing
    wr(8'h00, 32'h7, "R4");
    rd(8'h00, "R4");
    burst(60, "R5");
    rd(8'h0C, "R6");

    // R7 freeze and resume
    wr(8'h00, 32'h0, "R7");
    burst(30, "R7");
    wr(8'h00, 32'h1, "R7");
    burst(20, "R7");

    // R3 clear individual bits
    wr(8'h08, 32'h0000_0002, "R3");
    rd(8'h04, "R3");
    burst(24, "R3");
    wr(8'h08, 32'h8000_0000, "R3");
    burst(16, "R3");
    wr(8'h04, 32'h8000_0002, "R2");

    // R8 reset collides with strobes and ticks
    burst(10, "R8");
    step(1'b1, 8'h00, 32'h3, 1'b1, 1'b1, "R8");
    rd(8'h20, "R8"); rd(8'h30, "R8"); rd(8'h0C, "R8");
    burst(10, "R8");
    step(1'b1, 8'h00, 32'h5, 1'b1, 1'b1, "R8");
    rd(8'h0C, "R8"); rd(8'h28, "R8");
    step(1'b1, 8'h00, 32'h7, 1'b1, 1'b1, "R8");
    rd(8'h24, "R8"); rd(8'h0C, "R8");

    // R11 enable in the same cycle as a beat
    wr(8'h08, 32'h0000_0001, "R11");
    step(1'b1, 8'h04, 32'h0000_0001, 1'b1, 1'b0, "R11");
    step(1'b0, 8'h20, 32'h0, 1'b1, 1'b0, "R11");
    rd(8'h20, "R11");
    wr(8'h00, 32'h0, "R11");
    step(1'b1, 8'h00, 32'h1, 1'b1, 1'b1, "R11");
    rd(8'h20, "R11"); rd(8'h0C, "R11");

    // R10 writes to counters and holes
    wr(8'h20, 32'hDEAD_BEEF, "R10"); rd(8'h20, "R10");
    wr(8'h2C, 32'hFFFF_FFFF, "R10"); rd(8'h2C, "R10");
    wr(8'h30, 32'h1234_5678, "R10"); rd(8'h30, "R10");
    wr(8'h0C, 32'h55, "R10"); rd(8'h0C, "R10");
    wr(8'h40, 32'hFFFF_FFFF, "R10"); rd(8'h40, "R10");
    wr(8'h06, 32'hFFFF_FFFF, "R10"); rd(8'h06, "R10"); rd(8'h04, "R10");
    rd(8'hFC, "R10");

    // R9 split readout of the wide counter
    burst(40, "R9");
    rd(8'h2C, "R9"); rd(8'h30, "R9");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule